// File: doc/BRIEF.md
# Latched Event Status and Interrupt Controller

This block records short-lived conditions from surrounding logic in a bank of sticky status bits. A host reaches the bank through a plain synchronous register port, where it can read the status bits and write a per-bit interrupt enable mask. It drives a single active-low interrupt line. Each event input is edge-detected, so a condition that stays asserted is counted once, not on every cycle.

A host clears status bits by writing a byte in which each 1 selects a bit to clear. An event that lands in the same cycle as its own clear wins, so no occurrence is lost. A polling host can therefore clear one bit safely. It writes the selector, reads the register, ANDs the result with the selector and writes that value back. Any event that arrived in between stays latched.

Release of the interrupt is a separate step from the status clear. Each bit carries a pending flag. A read of the status register acknowledges every pending flag whose status bit reads as 1. The interrupt line is low while any pending flag is also enabled in the mask register.

Top module: `evl_top`

## Requirements
- R1: After reset the status bits, the pending flags and the mask register are all zero, and `irq_n_o` is 1.
- R2: A 0-to-1 transition on `evt_i[i]` sets status bit i at the next clock edge. An input held at 1 sets the bit only once: after the bit is cleared it stays 0 until the input falls and rises again.
- R3: A write (`wr_en_i`=1) to address 0 clears every status bit whose `wdata_i` bit is 1 and leaves every other status bit unchanged.
- R4: When a rising event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `rdata_o` is combinational. It returns the status bits at address 0 and the mask register at address 1. A write to address 1 loads the mask register. Addresses 2 and 3 read as 0, and writes to them change nothing.
- R6: `irq_n_o` is 0 exactly when some bit has its pending flag set and its mask bit at 1. With the mask at 0 the line stays high, and pending flags still latch.
- R7: A read (`rd_en_i`=1) of address 0 clears the pending flag of each bit whose status reads as 1 in that cycle, unless a new rising event for that bit arrives in the same cycle. The read leaves the status bits unchanged.
- R8: Clearing a status bit does not clear its pending flag. The interrupt stays asserted until a read acknowledges that flag.
- R9: A write-read-write clear of one bit removes only that bit. An event that rises on another bit during the sequence stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT | Event condition levels, one per status bit |
| addr_i | input | ADDR_W | Register address: 0 status, 1 interrupt mask |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe (acknowledge) |
| wdata_i | input | NUM_EVT | Write data: clear selector or mask value |
| rdata_o | output | NUM_EVT | Read data for the addressed register |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions assume the event inputs and the access strobes are synchronous to `clk` and stable around its rising edge. They also assume a cycle with both strobes carries one address. The bench drives every input half a period away from the rising edge, and it holds each event level for whole cycles. The same-cycle collisions behind R4, R7 and R9 are made on purpose by aligning an event rise with the write or read strobe. The random phase draws events, addresses and strobes independently, so it also produces these collisions.

// File: rtl/evl_pkg.sv
package evl_pkg;
  localparam int STAT_ADDR = 0;
  localparam int MASK_ADDR = 1;

  // next value of one status bit: a new occurrence outranks a clear
  function automatic logic stat_next(input logic cur, input logic rise, input logic clr);
    return rise | (cur & ~clr);
  endfunction

  // next value of one pending flag: a new occurrence outranks an acknowledge
  function automatic logic pend_next(input logic cur, input logic rise, input logic ack);
    return rise | (cur & ~ack);
  endfunction
endpackage

// File: rtl/evl_edge.sv
module evl_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/evl_bank.sv
module evl_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] pend_o
);
  import evl_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_o[i] <= 1'b0;
        pend_o[i]   <= 1'b0;
      end else begin
        status_o[i] <= stat_next(status_o[i], rise_i[i], clr_i[i]);
        pend_o[i]   <= pend_next(pend_o[i], rise_i[i], ack_i[i]);
      end
    end
  end
endmodule

// File: rtl/evl_port.sv
module evl_port #(
  parameter int N      = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      ack_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      rdata_o
);
  import evl_pkg::*;

  logic sel_stat, sel_mask;
  assign sel_stat = (addr_i == ADDR_W'(STAT_ADDR));
  assign sel_mask = (addr_i == ADDR_W'(MASK_ADDR));

  assign clr_o = (wr_en_i && sel_stat) ? wdata_i  : '0;
  assign ack_o = (rd_en_i && sel_stat) ? status_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   mask_o <= '0;
    else if (wr_en_i && sel_mask) mask_o <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_stat)      rdata_o = status_i;
    else if (sel_mask) rdata_o = mask_o;
  end
endmodule

// File: rtl/evl_top.sv
module evl_top #(
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] rdata_o,
  output logic               irq_n_o
);
  logic [NUM_EVT-1:0] rise_w, clr_w, ack_w, status_w, pend_w, mask_w;

  evl_edge #(.N(NUM_EVT)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(evt_i), .rise_o(rise_w)
  );

  evl_bank #(.N(NUM_EVT)) u_bank (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .clr_i(clr_w), .ack_i(ack_w),
    .status_o(status_w), .pend_o(pend_w)
  );

  evl_port #(.N(NUM_EVT), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .status_i(status_w),
    .clr_o(clr_w), .ack_o(ack_w), .mask_o(mask_w), .rdata_o(rdata_o)
  );

  assign irq_n_o = ~|(pend_w & mask_w);
endmodule

// File: rtl/evl_checker.sv
module evl_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq_n,
  input logic [N-1:0] status,
  input logic [N-1:0] pend,
  input logic [N-1:0] mask,
  input logic [N-1:0] rise,
  input logic [N-1:0] clr,
  input logic [N-1:0] ack
);
  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((status & $past(rise)) == $past(rise)));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~rise)) |=> ((status & $past(clr & ~rise)) == '0));

  a_r3_others_keep: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(clr | rise)) == ($past(status) & ~$past(clr | rise))));

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irq_n);

  a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & ~rise)) |=> ((pend & $past(ack & ~rise)) == '0));

  a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & ~ack)) == $past(pend & ~ack)));
endmodule

bind evl_top evl_checker #(.N(NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n_o), .status(status_w), .pend(pend_w),
  .mask(mask_w), .rise(rise_w), .clr(clr_w), .ack(ack_w)
);

// File: tb/sim_evl_top.sv
module sim_evl_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdat = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [7:0] last_rd;
  logic       last_irq;

  // behavioural reference state
  bit m_stat[8];
  bit m_pend[8];
  bit m_mask[8];
  bit m_prev[8];

  evl_top u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .addr_i(addr), .wr_en_i(wr),
    .rd_en_i(rd), .wdata_i(wdat), .rdata_o(rdata), .irq_n_o(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    int v = 0;
    for (int i = 0; i < 8; i++) begin
      if (a == 0 && m_stat[i]) v += (1 << i);
      if (a == 1 && m_mask[i]) v += (1 << i);
    end
    return v;
  endfunction

  function automatic bit model_irq_n();
    for (int i = 0; i < 8; i++)
      if (m_pend[i] && m_mask[i]) return 1'b0;
    return 1'b1;
  endfunction

  // one cycle: drive at negedge, compare, advance the model at the posedge
  task automatic step(input logic [7:0] ev, input int a, input bit w, input bit r, input logic [7:0] d);
    bit rise;
    bit old_stat;
    evt = ev; addr = 2'(a); wr = w; rd = r; wdat = d;
    #1;
    last_rd = rdata; last_irq = irq_n;
    chk(int'(rdata) == model_read(a), "R5 read data", int'(rdata), model_read(a));
    chk(irq_n == model_irq_n(), "R6 interrupt line", int'(irq_n), int'(model_irq_n()));
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      rise = ev[i] && !m_prev[i];
      old_stat = m_stat[i];
      if (rise) m_stat[i] = 1;
      else if (w && a == 0 && d[i]) m_stat[i] = 0;
      if (rise) m_pend[i] = 1;
      else if (r && a == 0 && old_stat) m_pend[i] = 0;
      if (w && a == 1) m_mask[i] = d[i];
      m_prev[i] = ev[i];
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    step(8'h00, 0, 0, 0, 8'h00); chk(last_rd == 8'h00, "R1 status", last_rd, 0);
    chk(last_irq == 1'b1, "R1 irq_n", last_irq, 1);
    step(8'h00, 1, 0, 0, 8'h00); chk(last_rd == 8'h00, "R1 mask", last_rd, 0);

    // R2 rising edge sets, held level sets once
    step(8'h09, 2, 0, 0, 8'h00);
    step(8'h09, 0, 0, 1, 8'h00); chk(last_rd == 8'h09, "R2 set by rise", last_rd, 8'h09);
    step(8'h09, 0, 1, 0, 8'h08);
    step(8'h09, 0, 0, 0, 8'h00); chk(last_rd == 8'h01, "R2 held level no reset / R3 keep", last_rd, 8'h01);

    // R5 mask register and unused addresses
    step(8'h00, 1, 1, 0, 8'h21);
    step(8'h00, 1, 0, 0, 8'h00); chk(last_rd == 8'h21, "R5 mask readback", last_rd, 8'h21);
    step(8'h00, 2, 1, 0, 8'hFF);
    step(8'h00, 2, 0, 0, 8'h00); chk(last_rd == 8'h00, "R5 unused reads zero", last_rd, 0);
    step(8'h00, 1, 0, 0, 8'h00); chk(last_rd == 8'h21, "R5 unused write ignored", last_rd, 8'h21);
    chk(last_irq == 1'b1, "R7 earlier read acked", last_irq, 1);

    // R6 / R8: enabled event asserts, clear does not release
    step(8'h20, 2, 0, 0, 8'h00);
    step(8'h20, 2, 0, 0, 8'h00); chk(last_irq == 1'b0, "R6 enabled event", last_irq, 0);
    step(8'h20, 0, 1, 0, 8'h20);
    step(8'h20, 0, 0, 0, 8'h00); chk(last_rd == 8'h01, "R3 selective clear", last_rd, 8'h01);
    chk(last_irq == 1'b0, "R8 clear keeps interrupt", last_irq, 0);

    // R7: new occurrence, read acknowledges, status kept
    step(8'h00, 2, 0, 0, 8'h00);
    step(8'h20, 2, 0, 0, 8'h00);
    step(8'h20, 0, 0, 1, 8'h00); chk(last_rd == 8'h21, "R7 read value", last_rd, 8'h21);
    step(8'h20, 0, 0, 0, 8'h00); chk(last_irq == 1'b1, "R7 ack releases", last_irq, 1);
    chk(last_rd == 8'h21, "R7 read keeps status", last_rd, 8'h21);

    // R4: rise and clear of the same bit together
    step(8'h00, 2, 0, 0, 8'h00);
    step(8'h02, 0, 1, 0, 8'h02);
    step(8'h02, 0, 0, 0, 8'h00); chk(last_rd == 8'h23, "R4 set wins", last_rd, 8'h23);

    // R9: write-read-write with another event arriving meanwhile
    step(8'h43, 0, 1, 0, 8'h01);
    step(8'h43, 0, 0, 1, 8'h00); chk(last_rd == 8'h63, "R9 mid read", last_rd, 8'h63);
    rv = last_rd & 8'h01;
    step(8'h43, 0, 1, 0, rv);
    step(8'h43, 0, 0, 0, 8'h00); chk(last_rd == 8'h62, "R9 only target cleared", last_rd, 8'h62);

    // random traffic compared against the model every cycle
    void'($urandom(7));
    for (int k = 0; k < 400; k++) begin
      int a = $urandom_range(0, 3);
      step(8'($urandom), a, 1'($urandom), 1'($urandom), 8'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule